// File: doc/BRIEF.md
# CAN Fault Confinement Counter Unit

This block keeps the two error counters of a CAN 2.0B node and derives the node's error state from them. It also runs the bus-off recovery sequence. The protocol engine feeds it single-cycle event strobes: transmitter error, receiver error, a good transmission, a good reception, a bit error inside an error or overload flag, too many dominant bits after a flag, and a stuff error found during arbitration. A bit-time strobe comes with the sampled bus level, and the unit uses it to count bus-free sequences while it recovers.

The block also makes a warning status bit. This bit compares both counters with a programmable limit, and a one-cycle interrupt pulse marks each change of that bit. A reset-mode input freezes both counters. A listen-only input makes the node deaf to transmit-side events. After bus-off, the recovery count is kept in the transmit counter. The warning bit and the receive counter stay still while recovery runs, so a falling count cannot raise a false warning interrupt. A receive counter that is not zero also cannot stall recovery.

Top module: `can_errcnt_unit`

## Requirements
- R1: After synchronous reset the outputs are as follows: both counters 0, error state active (code 0), warning bit 0, interrupt 0, recovery-done 0.
- R2: Each of three conditions adds 8 to the transmit counter: a transmitter error, a bit error in an active error or overload flag, or excess dominant bits after a flag. Several of these in one cycle still add only 8. A good transmission subtracts 1, stops at 0, and has no effect in a cycle that also carries a penalty.
- R3: A transmitter error that comes together with the arbitration-stuff strobe adds nothing. A flag bit error or excess-dominant event in the same cycle or in a later cycle still adds 8.
- R4: A receiver error adds 1 to the receive counter, which stops at 255. A good reception with the counter above 127 loads it with 120. Otherwise a good reception subtracts 1, stopping at 0.
- R5: The error state reads passive (code 1) while either counter is 128 or more and the node is not bus-off. Otherwise it reads active (code 0).
- R6: A penalty that would take the transmit counter past 255 enters bus-off (code 2). The transmit counter is loaded with 128, and from then on all counter events are ignored.
- R7: Recovery starts only after reset mode has been raised and then released while bus-off. Each run of 11 consecutive recessive bit samples takes 1 from the transmit counter, and a dominant sample restarts the run. When the counter reaches 0, both counters clear, the state returns to active and recovery-done pulses for one cycle.
- R8: While reset mode is high, neither counter changes.
- R9: The receive counter does not change during bus-off, and its value has no effect on when recovery completes.
- R10: In normal operation the warning bit is 1 when either counter is at or above the limit. It follows the counters one cycle later. It is forced to 1 on entering bus-off and held constant during recovery.
- R11: The warning interrupt is high for exactly one cycle, and only in the cycle in which the warning bit has just changed.
- R12: With listen-only high, transmit-side events leave the transmit counter unchanged, while receive events still count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_err | input | 1 | Transmitter sent an error frame |
| ev_arb_stuff | input | 1 | Current transmitter error is a stuff error in arbitration |
| ev_flag_bit_err | input | 1 | Bit error inside an active error or overload flag |
| ev_dom_excess | input | 1 | Too many dominant bits after an error or overload flag |
| ev_tx_ok | input | 1 | Frame transmitted successfully |
| ev_rx_err | input | 1 | Receiver detected an error |
| ev_rx_ok | input | 1 | Frame received successfully |
| cfg_reset_mode | input | 1 | Reset mode, freezes counters and arms recovery |
| cfg_listen_only | input | 1 | Listen-only, transmit-side events ignored |
| cfg_warn_limit | input | 8 | Warning limit (software default 96) |
| bit_tick | input | 1 | One strobe per sampled bit time |
| bit_recessive | input | 1 | Sampled bus level is recessive |
| tec_o | output | 8 | Transmit error counter / remaining recovery sequences |
| rec_o | output | 8 | Receive error counter |
| err_state_o | output | 2 | 0 active, 1 passive, 2 bus-off |
| warn_o | output | 1 | Warning status bit |
| warn_irq_o | output | 1 | One-cycle pulse on warning bit change |
| recov_done_o | output | 1 | One-cycle pulse when recovery completes |

## Verification
The hardest situation to reach is the middle of recovery, with the transmit counter far below the warning limit and a nonzero receive counter left over from before bus-off. To get there, the bench first pushes the receive counter off zero and then drives 32 transmitter errors. It toggles reset mode and then feeds about 1400 recessive bit samples, with a dominant sample placed inside one run. A monitor counts interrupt pulses across the whole recovery, so a warning that should stay frozen but moves is caught, along with a receive counter that moves or a completion that arrives early.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

    typedef enum logic [1:0] {
        ES_ACTIVE  = 2'd0,
        ES_PASSIVE = 2'd1,
        ES_BUSOFF  = 2'd2
    } err_state_t;

    typedef enum logic [1:0] {
        M_RUN       = 2'd0,
        M_BOFF_HOLD = 2'd1,
        M_BOFF_ARM  = 2'd2,
        M_RECOVER   = 2'd3
    } boff_mode_t;

    typedef struct packed {
        logic tx_err;
        logic arb_stuff;
        logic flag_bit_err;
        logic dom_excess;
        logic tx_ok;
    } tx_ev_t;

    // One penalty of PEN per cycle; an arbitration stuff error exempts only
    // the transmitter error it accompanies.
    function automatic logic tx_penalty(tx_ev_t e);
        return (e.tx_err & ~e.arb_stuff) | e.flag_bit_err | e.dom_excess;
    endfunction

endpackage

// File: rtl/errcnt_tx.sv
module errcnt_tx
    import errcnt_pkg::*;
#(
    parameter int CW      = 8,
    parameter int RUN_LEN = 11,
    parameter int SEQ_CNT = 128,
    parameter int PEN     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  tx_ev_t        ev,
    input  logic          listen_only,
    input  logic          reset_mode,
    input  logic          bit_tick,
    input  logic          bit_recessive,
    output logic [CW-1:0] tec,
    output boff_mode_t    mode,
    output logic          finish,
    output logic          done
);
    localparam int          RW  = $clog2(RUN_LEN);
    localparam logic [CW:0] TOP = {1'b0, {CW{1'b1}}};

    logic [RW-1:0] run_q;
    logic [CW:0]   sum;
    logic          seq_end;
    logic          pen;

    assign pen     = tx_penalty(ev);
    assign sum     = {1'b0, tec} + (CW+1)'(PEN);
    assign seq_end = (mode == M_RECOVER) && !reset_mode && bit_tick &&
                     bit_recessive && (run_q == RW'(RUN_LEN - 1));
    assign finish  = seq_end && (tec == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tec   <= '0;
            mode  <= M_RUN;
            run_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (mode)
                M_RUN: begin
                    run_q <= '0;
                    if (!reset_mode && !listen_only) begin
                        if (pen) begin
                            if (sum > TOP) begin
                                mode <= M_BOFF_HOLD;
                                tec  <= CW'(SEQ_CNT);
                            end else begin
                                tec <= sum[CW-1:0];
                            end
                        end else if (ev.tx_ok && tec != '0) begin
                            tec <= tec - 1'b1;
                        end
                    end
                end
                M_BOFF_HOLD: begin
                    if (reset_mode) mode <= M_BOFF_ARM;
                end
                M_BOFF_ARM: begin
                    run_q <= '0;
                    if (!reset_mode) mode <= M_RECOVER;
                end
                M_RECOVER: begin
                    if (!reset_mode && bit_tick) begin
                        if (!bit_recessive) begin
                            run_q <= '0;
                        end else if (seq_end) begin
                            run_q <= '0;
                            tec   <= tec - 1'b1;
                            if (finish) begin
                                mode <= M_RUN;
                                done <= 1'b1;
                            end
                        end else begin
                            run_q <= run_q + 1'b1;
                        end
                    end
                end
                default: mode <= M_RUN;
            endcase
        end
    end
endmodule

// File: rtl/errcnt_rx.sv
module errcnt_rx #(
    parameter int CW     = 8,
    parameter int RELOAD = 120,
    parameter int PASV   = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frozen,
    input  logic          clear,
    input  logic          rx_err,
    input  logic          rx_ok,
    output logic [CW-1:0] rec
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rec <= '0;
        end else if (!frozen) begin
            if (rx_err) begin
                if (rec != MAXV) rec <= rec + 1'b1;
            end else if (rx_ok) begin
                if (rec >= CW'(PASV))  rec <= CW'(RELOAD);
                else if (rec != '0)    rec <= rec - 1'b1;
            end
        end
    end
endmodule

// File: rtl/errcnt_warn.sv
module errcnt_warn
    import errcnt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] tec,
    input  logic [CW-1:0] rec,
    input  logic [CW-1:0] limit,
    input  boff_mode_t    mode,
    output logic          warn,
    output logic          irq
);
    logic warn_d;

    always_comb begin
        unique case (mode)
            M_RUN:       warn_d = (tec >= limit) || (rec >= limit);
            M_BOFF_HOLD: warn_d = 1'b1;
            default:     warn_d = warn;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            warn <= 1'b0;
            irq  <= 1'b0;
        end else begin
            warn <= warn_d;
            irq  <= (warn_d != warn);
        end
    end
endmodule

// File: rtl/can_errcnt_unit.sv
module can_errcnt_unit
    import errcnt_pkg::*;
#(
    parameter int CW      = 8,
    parameter int RUN_LEN = 11,
    parameter int SEQ_CNT = 128,
    parameter int PEN     = 8,
    parameter int RELOAD  = 120,
    parameter int PASV    = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_tx_err,
    input  logic          ev_arb_stuff,
    input  logic          ev_flag_bit_err,
    input  logic          ev_dom_excess,
    input  logic          ev_tx_ok,
    input  logic          ev_rx_err,
    input  logic          ev_rx_ok,
    input  logic          cfg_reset_mode,
    input  logic          cfg_listen_only,
    input  logic [CW-1:0] cfg_warn_limit,
    input  logic          bit_tick,
    input  logic          bit_recessive,
    output logic [CW-1:0] tec_o,
    output logic [CW-1:0] rec_o,
    output logic [1:0]    err_state_o,
    output logic          warn_o,
    output logic          warn_irq_o,
    output logic          recov_done_o
);
    tx_ev_t     tx_ev;
    boff_mode_t boff_mode;
    logic       finish;
    err_state_t st;

    assign tx_ev = '{tx_err: ev_tx_err, arb_stuff: ev_arb_stuff,
                     flag_bit_err: ev_flag_bit_err, dom_excess: ev_dom_excess,
                     tx_ok: ev_tx_ok};

    errcnt_tx #(.CW(CW), .RUN_LEN(RUN_LEN), .SEQ_CNT(SEQ_CNT), .PEN(PEN)) u_tx (
        .clk           (clk),
        .rst           (rst),
        .ev            (tx_ev),
        .listen_only   (cfg_listen_only),
        .reset_mode    (cfg_reset_mode),
        .bit_tick      (bit_tick),
        .bit_recessive (bit_recessive),
        .tec           (tec_o),
        .mode          (boff_mode),
        .finish        (finish),
        .done          (recov_done_o)
    );

    errcnt_rx #(.CW(CW), .RELOAD(RELOAD), .PASV(PASV)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .frozen (cfg_reset_mode || (boff_mode != M_RUN)),
        .clear  (finish),
        .rx_err (ev_rx_err),
        .rx_ok  (ev_rx_ok),
        .rec    (rec_o)
    );

    errcnt_warn #(.CW(CW)) u_warn (
        .clk   (clk),
        .rst   (rst),
        .tec   (tec_o),
        .rec   (rec_o),
        .limit (cfg_warn_limit),
        .mode  (boff_mode),
        .warn  (warn_o),
        .irq   (warn_irq_o)
    );

    always_comb begin
        if (boff_mode != M_RUN)                               st = ES_BUSOFF;
        else if (tec_o >= CW'(PASV) || rec_o >= CW'(PASV))    st = ES_PASSIVE;
        else                                                  st = ES_ACTIVE;
    end
    assign err_state_o = st;
endmodule

// File: rtl/errcnt_chk.sv
module errcnt_chk
    import errcnt_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_tx_err,
    input logic          ev_arb_stuff,
    input logic          ev_flag_bit_err,
    input logic          ev_dom_excess,
    input logic          cfg_reset_mode,
    input logic          cfg_listen_only,
    input logic [CW-1:0] tec_o,
    input logic [CW-1:0] rec_o,
    input logic [1:0]    err_state_o,
    input logic          warn_o,
    input logic          warn_irq_o,
    input logic          recov_done_o,
    input boff_mode_t    mode
);
    logic normal;
    assign normal = (err_state_o != 2'(ES_BUSOFF)) && !cfg_reset_mode && !cfg_listen_only;

    // R2: flag-related errors always cost 8
    p_flag_pen_r2: assert property (@(posedge clk) disable iff (rst)
        (normal && (ev_flag_bit_err || ev_dom_excess) && tec_o < CW'(248))
        |=> tec_o == $past(tec_o) + CW'(8));

    // R3: arbitration stuff error alone never raises the counter
    p_arb_exempt_r3: assert property (@(posedge clk) disable iff (rst)
        (normal && ev_tx_err && ev_arb_stuff && !ev_flag_bit_err && !ev_dom_excess)
        |=> tec_o <= $past(tec_o));

    // R8: reset mode freezes both counters
    p_rm_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_reset_mode |=> ($stable(tec_o) && $stable(rec_o)));

    // R9: receive counter moves during bus-off only by the completion clear
    p_rec_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(err_state_o) == 2'(ES_BUSOFF) && rec_o != $past(rec_o)) |-> recov_done_o);

    // R10: warning bit frozen while recovery counts down
    p_warn_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RECOVER && $past(mode) == M_RECOVER) |-> $stable(warn_o));

    // R11: interrupt only with a real change
    p_irq_change_r11: assert property (@(posedge clk) disable iff (rst)
        warn_irq_o |-> (warn_o != $past(warn_o)));

    // R7: completion leaves a clean active node
    p_done_clean_r7: assert property (@(posedge clk) disable iff (rst)
        recov_done_o |-> (tec_o == '0 && rec_o == '0 && err_state_o == 2'(ES_ACTIVE)));

    // R12: listen-only keeps the transmit counter still
    p_listen_r12: assert property (@(posedge clk) disable iff (rst)
        (cfg_listen_only && err_state_o != 2'(ES_BUSOFF)) |=> $stable(tec_o));
endmodule

bind can_errcnt_unit errcnt_chk #(.CW(CW)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .ev_tx_err       (ev_tx_err),
    .ev_arb_stuff    (ev_arb_stuff),
    .ev_flag_bit_err (ev_flag_bit_err),
    .ev_dom_excess   (ev_dom_excess),
    .cfg_reset_mode  (cfg_reset_mode),
    .cfg_listen_only (cfg_listen_only),
    .tec_o           (tec_o),
    .rec_o           (rec_o),
    .err_state_o     (err_state_o),
    .warn_o          (warn_o),
    .warn_irq_o      (warn_irq_o),
    .recov_done_o    (recov_done_o),
    .mode            (boff_mode)
);

// File: tb/can_errcnt_unit_tb.sv
`timescale 1ns/1ps
module can_errcnt_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_tx_err = 0, ev_arb_stuff = 0, ev_flag_bit_err = 0, ev_dom_excess = 0;
    logic       ev_tx_ok = 0, ev_rx_err = 0, ev_rx_ok = 0;
    logic       cfg_reset_mode = 0, cfg_listen_only = 0;
    logic [7:0] cfg_warn_limit = 8'd96;
    logic       bit_tick = 0, bit_recessive = 1;
    logic [7:0] tec_o, rec_o;
    logic [1:0] err_state_o;
    logic       warn_o, warn_irq_o, recov_done_o;

    int vectors = 0;
    int fails   = 0;
    int irq_seen = 0;

    // event vector: {tx_err, arb_stuff, flag_bit_err, dom_excess, tx_ok, rx_err, rx_ok}
    localparam logic [6:0] E_TXE  = 7'b1000000;
    localparam logic [6:0] E_ARB  = 7'b0100000;
    localparam logic [6:0] E_FLAG = 7'b0010000;
    localparam logic [6:0] E_DOM  = 7'b0001000;
    localparam logic [6:0] E_TXOK = 7'b0000100;
    localparam logic [6:0] E_RXE  = 7'b0000010;
    localparam logic [6:0] E_RXOK = 7'b0000001;

    always #2 clk = ~clk;

    can_errcnt_unit dut_i (
        .clk(clk), .rst(rst),
        .ev_tx_err(ev_tx_err), .ev_arb_stuff(ev_arb_stuff),
        .ev_flag_bit_err(ev_flag_bit_err), .ev_dom_excess(ev_dom_excess),
        .ev_tx_ok(ev_tx_ok), .ev_rx_err(ev_rx_err), .ev_rx_ok(ev_rx_ok),
        .cfg_reset_mode(cfg_reset_mode), .cfg_listen_only(cfg_listen_only),
        .cfg_warn_limit(cfg_warn_limit), .bit_tick(bit_tick), .bit_recessive(bit_recessive),
        .tec_o(tec_o), .rec_o(rec_o), .err_state_o(err_state_o),
        .warn_o(warn_o), .warn_irq_o(warn_irq_o), .recov_done_o(recov_done_o)
    );

    always @(negedge clk) if (!rst && warn_irq_o) irq_seen++;

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_reset_mode = 0; cfg_listen_only = 0; cfg_warn_limit = 8'd96;
        bit_tick = 0; bit_recessive = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe(input logic [6:0] v);
        @(negedge clk);
        {ev_tx_err, ev_arb_stuff, ev_flag_bit_err, ev_dom_excess, ev_tx_ok, ev_rx_err, ev_rx_ok} = v;
        @(negedge clk);
        {ev_tx_err, ev_arb_stuff, ev_flag_bit_err, ev_dom_excess, ev_tx_ok, ev_rx_err, ev_rx_ok} = '0;
    endtask

    task automatic tick(input logic r);
        @(negedge clk);
        bit_tick = 1'b1; bit_recessive = r;
        @(negedge clk);
        bit_tick = 1'b0; bit_recessive = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 tec", tec_o, 0);
        check("R1 rec", rec_o, 0);
        check("R1 state", err_state_o, 0);
        check("R1 warn", warn_o, 0);
        check("R1 irq/done", {warn_irq_o, recov_done_o}, 0);
    endtask

    task automatic t_tx_basic();
        do_reset();
        strobe(E_TXOK);
        check("R2 tx_ok floor", tec_o, 0);
        strobe(E_TXE);
        check("R2 tx_err +8", tec_o, 8);
        strobe(E_TXOK);
        check("R2 tx_ok -1", tec_o, 7);
        strobe(E_TXE | E_FLAG | E_DOM | E_TXOK);
        check("R2 combined single penalty", tec_o, 15);
    endtask

    task automatic t_arb_stuff();
        do_reset();
        strobe(E_TXE | E_ARB);
        check("R3 arb stuff exempt", tec_o, 0);
        strobe(E_FLAG);
        check("R3 later flag bit error", tec_o, 8);
        strobe(E_DOM);
        check("R3 later dominant excess", tec_o, 16);
        strobe(E_TXE | E_ARB | E_FLAG);
        check("R3 same-cycle flag error", tec_o, 24);
    endtask

    task automatic t_rx();
        do_reset();
        strobe(E_RXOK);
        check("R4 rx_ok floor", rec_o, 0);
        for (int i = 0; i < 130; i++) strobe(E_RXE);
        check("R4 rx count", rec_o, 130);
        check("R5 rec passive", err_state_o, 1);
        strobe(E_RXOK);
        check("R4 reload", rec_o, 120);
        check("R5 back active", err_state_o, 0);
        strobe(E_RXOK);
        check("R4 rx_ok -1", rec_o, 119);
        for (int i = 0; i < 140; i++) strobe(E_RXE);
        check("R4 saturate", rec_o, 255);
    endtask

    task automatic t_passive_warn();
        do_reset();
        irq_seen = 0;
        for (int i = 0; i < 12; i++) strobe(E_TXE);
        check("R2 twelve errors", tec_o, 96);
        check("R10 warn lags", warn_o, 0);
        @(negedge clk);
        check("R10 warn set", warn_o, 1);
        check("R11 irq pulse", warn_irq_o, 1);
        @(negedge clk);
        check("R11 irq single", warn_irq_o, 0);
        for (int i = 0; i < 3; i++) strobe(E_TXE);
        check("R5 at 120 active", err_state_o, 0);
        strobe(E_TXE);
        check("R5 at 128 passive", err_state_o, 1);
        check("R11 one irq total", irq_seen, 1);
        cfg_warn_limit = 8'd200;
        @(negedge clk); @(negedge clk);
        check("R10 limit raise clears", warn_o, 0);
        check("R11 irq count", irq_seen, 2);
    endtask

    task automatic t_freeze();
        do_reset();
        strobe(E_TXE);
        strobe(E_RXE);
        cfg_reset_mode = 1'b1;
        strobe(E_TXE);
        strobe(E_RXE);
        strobe(E_RXOK | E_TXOK);
        check("R8 tec frozen", tec_o, 8);
        check("R8 rec frozen", rec_o, 1);
        cfg_reset_mode = 1'b0;
        cfg_listen_only = 1'b1;
        strobe(E_TXE);
        strobe(E_TXOK);
        strobe(E_FLAG);
        check("R12 tec ignores tx events", tec_o, 8);
        strobe(E_RXE);
        check("R12 rec still counts", rec_o, 2);
        cfg_listen_only = 1'b0;
    endtask

    task automatic t_busoff();
        do_reset();
        for (int i = 0; i < 3; i++) strobe(E_RXE);
        for (int i = 0; i < 31; i++) strobe(E_TXE);
        check("R2 tec 248", tec_o, 248);
        strobe(E_TXE);
        check("R6 busoff state", err_state_o, 2);
        check("R6 tec loaded", tec_o, 128);
        @(negedge clk);
        check("R10 warn in busoff", warn_o, 1);
        strobe(E_RXE);
        strobe(E_TXE);
        check("R9 rec held", rec_o, 3);
        check("R6 tec ignores events", tec_o, 128);
        for (int i = 0; i < 11; i++) tick(1'b1);
        check("R7 no count before reset mode", tec_o, 128);
        irq_seen = 0;
        @(negedge clk); cfg_reset_mode = 1'b1;
        @(negedge clk); cfg_reset_mode = 1'b0;
        for (int i = 0; i < 10; i++) tick(1'b1);
        tick(1'b0);
        for (int i = 0; i < 10; i++) tick(1'b1);
        check("R7 dominant restarts run", tec_o, 128);
        tick(1'b1);
        check("R7 first sequence", tec_o, 127);
        for (int s = 0; s < 126; s++)
            for (int i = 0; i < 11; i++) tick(1'b1);
        check("R7 one left", tec_o, 1);
        check("R7 still busoff", err_state_o, 2);
        check("R10 warn frozen", warn_o, 1);
        check("R11 no irq in recovery", irq_seen, 0);
        check("R9 rec held in recovery", rec_o, 3);
        for (int i = 0; i < 11; i++) tick(1'b1);
        check("R7 tec cleared", tec_o, 0);
        check("R9 rec cleared", rec_o, 0);
        check("R7 active", err_state_o, 0);
        check("R7 done pulse", recov_done_o, 1);
        @(negedge clk);
        check("R7 done single", recov_done_o, 0);
        check("R10 warn released", warn_o, 0);
        check("R11 irq on release", warn_irq_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_tx_basic();
        t_arb_stuff();
        t_rx();
        t_passive_warn();
        t_freeze();
        t_busoff();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule